// File: doc/BRIEF.md
# Dual-Width Transmit Serializer

This block turns parallel words of 8b/10b characters into a serial bit stream, one bit per cycle of a bit-rate clock. A width select picks between a narrow word of one 10-bit character and a wide word of two characters. A reference-tick strobe arrives once every ten bit times and stands in for the reference clock edge. On selected ticks the parallel bus and the width select are captured into an input latch. When the shift register sends the last bit of its word, it reloads from that latch in the same cycle, so the stream has no gaps between words.

In narrow mode only the upper half of the bus carries the character. The serial stream starts at bus bit 10. In wide mode the whole bus is sent, starting at bus bit 0. In both modes bits go out in ascending index order. Each 10-bit character is laid out so that ascending offsets carry the code letters a, b, c, d, e, i, f, g, h, j. Each of the two serial outputs has its own enable. A word-rate clock output marks where each word starts and ends.

Top module: `ser_dw_tx`

## Requirements
- R1: While reset is held and after it is released, the shift register holds the idle character 10'h17C as a narrow word and the word clock is high. The first ten serial bits after release are the idle character, least significant bit first.
- R2: A narrow word (width select 0) sends bus bits 10 to 19 in ascending order over ten bit times. Bus bits 0 to 9 have no effect on the stream.
- R3: A wide word (width select 1) sends bus bits 0 to 19 in ascending order over twenty bit times.
- R4: The latch captures the bus and the width select only on a tick that falls in the last ten bit times of the word being sent. A tick in the first half of a wide word is ignored. So narrow words use every tick and wide words use every second tick.
- R5: The next word's first bit follows the previous word's last bit in the very next bit time, with no idle bit times between them.
- R6: A width change applies only from the word boundary after the capture that carried it. The width of a word in flight never changes.
- R7: Inside a character, offsets 0 to 9 carry the letters a, b, c, d, e, i, f, g, h, j in that order: letter i is the sixth bit sent and letter f is the seventh.
- R8: Serial output k equals the serialized bit while enable k is 1, and is 0 while enable k is 0. Shifting goes on regardless, so the stream stays aligned.
- R9: The word clock is high for the first half of each word and low for the second half. Its period is 10 bit times in narrow mode and 20 bit times in wide mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe, once every ten bit times |
| wide_sel | input | 1 | Width select: 0 one character, 1 two characters |
| par_data | input | 20 | Parallel input word |
| oe | input | 2 | Enable for each serial output |
| ser_out | output | 2 | Serial data outputs, held low when disabled |
| word_clk | output | 1 | Word-rate clock |

## Verification
The bench builds the block with its default parameters:
- 10-bit characters.
- Two serial outputs.
- The idle character 10'h17C.

These values bring both word lengths within reach, as well as every order in which narrow and wide words can follow each other, including changes in both directions.

For each word that follows a wide word, the bench drives a decoy value with the opposite width on the ignored first-half tick. Any capture at the wrong time therefore shows up in the stream. Enable patterns with different periods cover each output gated on and off at every bit position.

// File: rtl/ser_dw_pkg.sv
package ser_dw_pkg;
  typedef enum logic {
    WID_NARROW = 1'b0,
    WID_WIDE   = 1'b1
  } width_e;
endpackage

// File: rtl/ser_dw_rst_sync.sv
module ser_dw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stg_q;

  // Assert asynchronously, release after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q      <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stg_q      <= 1'b1;
      rst_n_sync <= stg_q;
    end
  end
endmodule

// File: rtl/ser_dw_latch.sv
module ser_dw_latch
  import ser_dw_pkg::*;
#(
  parameter int               CHAR_W    = 10,
  parameter logic [CHAR_W-1:0] IDLE_CHAR = '0,
  localparam int              BUS_W     = 2 * CHAR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             wide_in,
  input  logic [BUS_W-1:0] bus_in,
  output width_e           lat_mode,
  output logic [BUS_W-1:0] lat_bus
);
  width_e           mode_d;
  logic [BUS_W-1:0] bus_d;

  always_comb begin
    mode_d = lat_mode;
    bus_d  = lat_bus;
    if (cap_en) begin
      mode_d = wide_in ? WID_WIDE : WID_NARROW;
      bus_d  = bus_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_mode <= WID_NARROW;
      lat_bus  <= {IDLE_CHAR, {CHAR_W{1'b0}}};
    end else begin
      lat_mode <= mode_d;
      lat_bus  <= bus_d;
    end
  end

  // R4: only an enabled tick moves the latch contents.
  a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(lat_bus) && $stable(lat_mode));
  a_r4_latch_take: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> lat_bus == $past(bus_in));
endmodule

// File: rtl/ser_dw_shift.sv
module ser_dw_shift
  import ser_dw_pkg::*;
#(
  parameter int               CHAR_W    = 10,
  parameter logic [CHAR_W-1:0] IDLE_CHAR = '0,
  localparam int              BUS_W     = 2 * CHAR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  width_e           lat_mode,
  input  logic [BUS_W-1:0] lat_bus,
  output logic             ser_bit,
  output logic             word_clk,
  output logic             last_slot
);
  localparam int CNT_W  = $clog2(BUS_W);
  localparam int HALF_N = CHAR_W / 2;

  logic [BUS_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, len_m1;
  width_e           mode_q, mode_d;
  logic             wclk_d, at_end;

  always_comb begin
    len_m1    = (mode_q == WID_WIDE) ? CNT_W'(BUS_W - 1) : CNT_W'(CHAR_W - 1);
    at_end    = (cnt_q == len_m1);
    last_slot = (mode_q == WID_NARROW) || (cnt_q >= CNT_W'(CHAR_W));
    if (at_end) begin
      cnt_d  = '0;
      mode_d = lat_mode;
      sh_d   = (lat_mode == WID_WIDE) ? lat_bus
             : {{CHAR_W{1'b0}}, lat_bus[BUS_W-1 -: CHAR_W]};
    end else begin
      cnt_d  = cnt_q + CNT_W'(1);
      mode_d = mode_q;
      sh_d   = {1'b0, sh_q[BUS_W-1:1]};
    end
    wclk_d = (mode_d == WID_WIDE) ? (cnt_d < CNT_W'(CHAR_W))
                                  : (cnt_d < CNT_W'(HALF_N));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= {{CHAR_W{1'b0}}, IDLE_CHAR};
      cnt_q    <= '0;
      mode_q   <= WID_NARROW;
      word_clk <= 1'b1;
    end else begin
      sh_q     <= sh_d;
      cnt_q    <= cnt_d;
      mode_q   <= mode_d;
      word_clk <= wclk_d;
    end
  end

  assign ser_bit = sh_q[0];

  // R5: within a word the position advances by exactly one each bit time.
  a_r5_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> cnt_q == $past(cnt_q) + CNT_W'(1));
  // R6: width of a word in flight never changes.
  a_r6_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $stable(mode_q));
  // R2/R3: bits leave in ascending order.
  a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> ser_bit == $past(sh_q[1]));
  // R9: the word clock only rises at a word start.
  a_r9_wclk_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_clk) |-> cnt_q == '0);
endmodule

// File: rtl/ser_dw_oe_gate.sv
module ser_dw_oe_gate #(
  parameter int NUM_OUT = 2
) (
  input  logic               ser_bit,
  input  logic [NUM_OUT-1:0] oe,
  output logic [NUM_OUT-1:0] ser_out
);
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_lane
    assign ser_out[k] = oe[k] & ser_bit;
  end
endmodule

// File: rtl/ser_dw_tx.sv
module ser_dw_tx
  import ser_dw_pkg::*;
#(
  parameter int               CHAR_W    = 10,
  parameter int               NUM_OUT   = 2,
  parameter logic [CHAR_W-1:0] IDLE_CHAR = 10'h17C,
  localparam int              BUS_W     = 2 * CHAR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_tick,
  input  logic               wide_sel,
  input  logic [BUS_W-1:0]   par_data,
  input  logic [NUM_OUT-1:0] oe,
  output logic [NUM_OUT-1:0] ser_out,
  output logic               word_clk
);
  logic             rst_n_i;
  logic             cap_en, last_slot, ser_bit;
  width_e           lat_mode;
  logic [BUS_W-1:0] lat_bus;

  ser_dw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  assign cap_en = ref_tick & last_slot;

  ser_dw_latch #(.CHAR_W(CHAR_W), .IDLE_CHAR(IDLE_CHAR)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .cap_en   (cap_en),
    .wide_in  (wide_sel),
    .bus_in   (par_data),
    .lat_mode (lat_mode),
    .lat_bus  (lat_bus)
  );

  ser_dw_shift #(.CHAR_W(CHAR_W), .IDLE_CHAR(IDLE_CHAR)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .lat_mode  (lat_mode),
    .lat_bus   (lat_bus),
    .ser_bit   (ser_bit),
    .word_clk  (word_clk),
    .last_slot (last_slot)
  );

  ser_dw_oe_gate #(.NUM_OUT(NUM_OUT)) u_gate (
    .ser_bit (ser_bit),
    .oe      (oe),
    .ser_out (ser_out)
  );
endmodule

// File: tb/ser_dw_tx_tb.sv
module ser_dw_tx_tb;
  localparam logic [9:0] IDLE = 10'h17C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ref_tick;
  logic        wide_sel;
  logic [19:0] par_data;
  logic [1:0]  oe;
  logic [1:0]  ser_out;
  logic        word_clk;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  logic [19:0] wd [16];
  bit          ww [16];
  int          lst[16];
  int          n_words;
  int          tlen;
  bit          eb [512];
  bit          ewc[512];
  bit          got[512];

  always #4 clk = ~clk;

  ser_dw_tx #(.CHAR_W(10), .NUM_OUT(2), .IDLE_CHAR(IDLE)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .wide_sel (wide_sel),
    .par_data (par_data),
    .oe       (oe),
    .ser_out  (ser_out),
    .word_clk (word_clk)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [9:0] letters(input bit a, b, c, d, e, f, g, h, i, j);
    return {j, h, g, f, i, e, d, c, b, a};
  endfunction

  task automatic build_expect();
    int pos = 10;
    for (int j = 0; j < 10; j++) begin
      eb[j]  = IDLE[j];
      ewc[j] = (j < 5);
    end
    for (int k = 0; k < n_words; k++) begin
      int len = ww[k] ? 20 : 10;
      lst[k] = pos;
      for (int j = 0; j < len; j++) begin
        eb[pos+j]  = ww[k] ? wd[k][j] : wd[k][10+j];
        ewc[pos+j] = (j < len / 2);
      end
      pos += len;
    end
    tlen = pos;
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; ref_tick = 1'b0; wide_sel = 1'b0; par_data = '0; oe = 2'b11;
    repeat (3) @(negedge clk);
    chk(ser_out === {2{IDLE[0]}}, "R1", "ser_out in reset", ser_out, {2{IDLE[0]}});
    chk(word_clk === 1'b1, "R1", "word_clk in reset", word_clk, 1);
    rst_n = 1'b1;
  endtask

  // Runs the word list; oe_mode 0 keeps both outputs on, 1 gates them.
  task automatic run_stream(input string tag, input int oe_mode);
    logic [1:0] oe_v;
    build_expect();
    apply_reset();
    @(posedge clk); @(posedge clk); @(negedge clk);
    for (int n = 0; n < tlen; n++) begin
      ref_tick = (((n + 1) % 10) == 5);
      for (int k = 0; k < n_words; k++) begin
        int prev = (k == 0) ? 0 : lst[k-1];
        if (n == prev) begin
          if (k > 0 && ww[k-1]) begin
            wide_sel = ~ww[k];           // decoy on the ignored tick (R4)
            par_data = wd[k] ^ 20'hA5A5A;
          end else begin
            wide_sel = ww[k];
            par_data = wd[k];
          end
        end
        if (k > 0 && ww[k-1] && n == prev + 10) begin
          wide_sel = ww[k];
          par_data = wd[k];
        end
      end
      oe_v = (oe_mode == 0) ? 2'b11 : {((n % 4) < 2), ((n % 3) != 0)};
      oe = oe_v;
      #1;
      got[n] = ser_out[0];
      chk(ser_out[0] === (oe_v[0] & eb[n]), (n < 10) ? "R1" : tag,
          $sformatf("ser_out[0] bit %0d", n), ser_out[0], oe_v[0] & eb[n]);
      chk(ser_out[1] === (oe_v[1] & eb[n]), (oe_mode != 0) ? "R8" : tag,
          $sformatf("ser_out[1] bit %0d", n), ser_out[1], oe_v[1] & eb[n]);
      chk(word_clk === ewc[n], "R9", $sformatf("word_clk bit %0d", n),
          word_clk, ewc[n]);
      @(negedge clk);
    end
    ref_tick = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ref_tick = 1'b0; wide_sel = 1'b1; par_data = '1; oe = 2'b11;
    repeat (4) @(negedge clk);
    chk(ser_out === {2{IDLE[0]}}, "R1", "reset output", ser_out, {2{IDLE[0]}});
    chk(word_clk === 1'b1, "R1", "reset word_clk", word_clk, 1);
  endtask

  // R2 and R5: narrow words back to back, junk in the low half.
  task automatic t_narrow();
    n_words = 6;
    for (int k = 0; k < n_words; k++) begin
      wd[k] = {10'(k * 97 + 13), 10'(~(k * 211))};
      ww[k] = 1'b0;
    end
    run_stream("R2", 0);
  endtask

  // R3 and R4: wide words, decoys on the first-half ticks.
  task automatic t_wide();
    n_words = 5;
    for (int k = 0; k < n_words; k++) begin
      wd[k] = 20'(k * 40503 + 777);
      ww[k] = 1'b1;
    end
    run_stream("R3", 0);
  endtask

  // R6 and R5: mixed widths, changes in both directions.
  task automatic t_mixed(input int oe_mode);
    bit pat[7] = '{0, 1, 1, 0, 1, 0, 0};
    n_words = 7;
    for (int k = 0; k < n_words; k++) begin
      wd[k] = 20'(k * 29917 + 4242);
      ww[k] = pat[k];
    end
    run_stream(oe_mode != 0 ? "R8" : "R6", oe_mode);
  endtask

  // R7: letter placement inside a character.
  task automatic t_letters();
    logic [9:0] ch;
    ch = letters(1, 0, 0, 1, 1, 1, 0, 1, 0, 1); // f=1, i=0
    n_words = 2;
    wd[0] = {ch, 10'h3FF}; ww[0] = 1'b0;
    wd[1] = {10'h000, ch}; ww[1] = 1'b1;
    run_stream("R7", 0);
    chk(got[15] === 1'b0, "R7", "narrow letter i at offset 5", got[15], 0);
    chk(got[16] === 1'b1, "R7", "narrow letter f at offset 6", got[16], 1);
    chk(got[19] === 1'b1, "R7", "narrow letter j at offset 9", got[19], 1);
    chk(got[25] === 1'b0, "R7", "wide letter i at offset 5", got[25], 0);
    chk(got[26] === 1'b1, "R7", "wide letter f at offset 6", got[26], 1);
  endtask

  initial begin
    t_reset();
    t_narrow();
    t_wide();
    t_mixed(0);
    t_mixed(1);
    t_letters();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule